// File: doc/BRIEF.md
# Supply Brown-out and Power-up Reset Sequencer

This block produces the system reset of a chip from three sources. The first is an asynchronous power-on reset input. The second is a comparator flag that reports when the supply is below the selected trip level. The third is a small set of configuration bits. While brown-out protection is active and the supply is low, the block holds the system in reset. Once the supply recovers, it can stretch the reset by a fixed power-up delay counted on a slow reference clock. If the supply dips again while that delay is running, the sequencer returns to the brown-out hold and the delay starts over from zero.

The trip-level field is passed straight to the analog comparator, which selects one of four brown-out settings. Level code 00 is a low-power setting. In that setting a low supply never resets the device. Instead, the block raises a re-arm request to the power-on-reset detector, so that a further drop still produces a clean power-on reset. A sticky status flag records that a brown-out reset took place. Only power-on reset or a software clear strobe removes it.

The comparator flag is asynchronous to the reference clock, so it passes through a two-flop synchroniser before any decision uses it.

Top module: `supply_reset_seq`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is 1 and `bo_flag_o` is 0. After `por_i` falls, the sequencer starts in the brown-out hold state.
- R2: When `bo_en_i` is 2'b00, a low supply neither asserts `sys_rst_o` nor raises `por_rearm_o`.
- R3: When `bo_en_i` is not 2'b00 and `bo_lvl_i` is not 2'b00, a high `vdd_low_i` asserts `sys_rst_o` on the third rising clock edge after the input changes, because of two synchroniser flops and one state flop. A high level that lasts a single cycle still causes this reset.
- R4: Under the conditions of R3, `sys_rst_o` stays 1 for as long as the synchronised supply-low flag stays 1.
- R5: With `pu_en_i` = 1, after the synchronised flag returns to 0, `sys_rst_o` stays 1 for PU_DELAY further reference-clock cycles and then falls.
- R6: With `pu_en_i` = 0, `sys_rst_o` falls on the first edge at which the synchronised flag is seen at 0. Enabling brown-out does not enable the delay.
- R7: A synchronised low supply during the power-up delay returns the sequencer to the hold state. The next recovery then waits the full PU_DELAY again.
- R8: When `bo_en_i` is not 2'b00 and `bo_lvl_i` is 2'b00 (low-power setting), a low supply never asserts `sys_rst_o`. In this setting `por_rearm_o` equals the synchronised supply-low flag.
- R9: `bo_flag_o` becomes 1 on the edge after any cycle in which a brown-out hold is in force. `flag_clr_i` clears the flag, but a simultaneous brown-out wins. `por_i` clears it asynchronously.
- R10: `lvl_sel_o` always equals `bo_lvl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow reference clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| vdd_low_i | input | 1 | Comparator flag: supply below trip level (asynchronous) |
| bo_en_i | input | 2 | Brown-out enable field; 00 disables |
| bo_lvl_i | input | 2 | Trip-level select; 00 selects the low-power setting |
| pu_en_i | input | 1 | Power-up delay enable |
| flag_clr_i | input | 1 | Software clear strobe for the brown-out status flag |
| sys_rst_o | output | 1 | System reset, active high |
| bo_flag_o | output | 1 | Sticky brown-out reset cause flag |
| por_rearm_o | output | 1 | Re-arm request to the power-on-reset detector |
| lvl_sel_o | output | 2 | Trip-level code forwarded to the comparator |

## Verification
A change on `vdd_low_i` reaches the state after three edges: two synchroniser flops and then the state register. The status flag follows one edge after the synchronised flag. `por_rearm_o` follows two edges after the input. `lvl_sel_o` follows combinationally in the same cycle. A behavioural reference model advances on the same rising edge as the design. It is compared on every falling edge, so each result is sampled half a cycle after the edge that makes it. Directed checks are placed at counted edge offsets. They sit on both sides of each expected transition: one edge early for the sync latency, and inside and beyond the power-up window for the delay and its restart.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_st_e;

  // Brown-out forces reset: enabled and a real trip level selected.
  function automatic logic bo_resets(input logic [1:0] en, input logic [1:0] lvl);
    return (en != 2'b00) && (lvl != 2'b00);
  endfunction

  // Low-power setting: enabled, level 00, re-arm instead of reset.
  function automatic logic bo_rearms(input logic [1:0] en, input logic [1:0] lvl);
    return (en != 2'b00) && (lvl == 2'b00);
  endfunction

endpackage

// File: rtl/supply_low_sync.sv
module supply_low_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) pipe_q <= '0;
    else       pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];

  // R3
  sync_follow_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $past(pipe_q[0]) == pipe_q[1]);
endmodule

// File: rtl/pu_delay_timer.sv
module pu_delay_timer #(
  parameter int PU_DELAY = 64
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (PU_DELAY > 1) ? $clog2(PU_DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(PU_DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)       cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == LAST);

  // R7
  timer_clear_chk: assert property (@(posedge clk_i) disable iff (por_i)
    !run_i |=> cnt_q == '0);

  // R5
  timer_step_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (run_i && !last_o) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/bo_cause_flag.sv
module bo_cause_flag (
  input  logic clk_i,
  input  logic por_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)      flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (por_i)
    set_i |=> flag_o);

  // R9
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import supply_reset_pkg::*;
#(
  parameter int PU_DELAY    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       vdd_low_i,
  input  logic [1:0] bo_en_i,
  input  logic [1:0] bo_lvl_i,
  input  logic       pu_en_i,
  input  logic       flag_clr_i,
  output logic       sys_rst_o,
  output logic       bo_flag_o,
  output logic       por_rearm_o,
  output logic [1:0] lvl_sel_o
);
  logic    low_s;
  logic    bo_mode;
  logic    lp_mode;
  logic    bo_hit;
  logic    delay_run;
  logic    delay_last;
  seq_st_e st_q, st_d;

  supply_low_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .async_i (vdd_low_i),
    .sync_o  (low_s)
  );

  assign bo_mode = bo_resets(bo_en_i, bo_lvl_i);
  assign lp_mode = bo_rearms(bo_en_i, bo_lvl_i);
  assign bo_hit  = bo_mode && low_s;

  pu_delay_timer #(.PU_DELAY(PU_DELAY)) u_timer (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .run_i  (delay_run),
    .last_o (delay_last)
  );

  assign delay_run = (st_q == SEQ_DELAY);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_HOLD: begin
        if (!bo_hit) st_d = pu_en_i ? SEQ_DELAY : SEQ_RUN;
      end
      SEQ_DELAY: begin
        if (bo_hit)          st_d = SEQ_HOLD;
        else if (delay_last) st_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (bo_hit) st_d = SEQ_HOLD;
      end
      default: st_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) st_q <= SEQ_HOLD;
    else       st_q <= st_d;
  end

  bo_cause_flag u_flag (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .set_i  (bo_hit),
    .clr_i  (flag_clr_i),
    .flag_o (bo_flag_o)
  );

  assign sys_rst_o   = (st_q != SEQ_RUN);
  assign por_rearm_o = lp_mode && low_s;
  assign lvl_sel_o   = bo_lvl_i;

  // R3
  bo_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
    bo_hit |=> sys_rst_o);

  // R6
  no_delay_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q == SEQ_HOLD && !bo_hit && !pu_en_i) |=> !sys_rst_o);

  // R7
  delay_abort_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q == SEQ_DELAY && bo_hit) |=> st_q == SEQ_HOLD);

  // R8
  lp_no_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (lp_mode && st_q == SEQ_RUN) |=> !sys_rst_o);

  // R2
  off_no_rearm_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (bo_en_i == 2'b00) |-> !por_rearm_o);
endmodule

// File: tb/supply_reset_seq_test.sv
module supply_reset_seq_test;
  localparam int PU_DELAY = 64;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       vdd_low = 1'b0;
  logic [1:0] bo_en = 2'b01;
  logic [1:0] bo_lvl = 2'b10;
  logic       pu_en = 1'b1;
  logic       flag_clr = 1'b0;
  logic       sys_rst, bo_flag, por_rearm;
  logic [1:0] lvl_sel;

  int total = 0;
  int fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  supply_reset_seq #(.PU_DELAY(PU_DELAY)) uut (
    .clk_i       (clk),
    .por_i       (por),
    .vdd_low_i   (vdd_low),
    .bo_en_i     (bo_en),
    .bo_lvl_i    (bo_lvl),
    .pu_en_i     (pu_en),
    .flag_clr_i  (flag_clr),
    .sys_rst_o   (sys_rst),
    .bo_flag_o   (bo_flag),
    .por_rearm_o (por_rearm),
    .lvl_sel_o   (lvl_sel)
  );

  // Behavioural reference model: 0 = held, 1 = delaying, 2 = running.
  int m_s1, m_s2, m_st, m_cnt, m_flag;

  always @(posedge clk or posedge por) begin
    if (por) begin
      m_s1 = 0; m_s2 = 0; m_st = 0; m_cnt = 0; m_flag = 0;
    end else begin
      bit forcing;
      forcing = (bo_en != 0) && (bo_lvl != 0) && (m_s2 == 1);
      if (forcing) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (m_st == 0) begin
        m_cnt = 0;
        if (!forcing) m_st = pu_en ? 1 : 2;
      end else if (m_st == 1) begin
        if (forcing) begin m_st = 0; m_cnt = 0; end
        else if (m_cnt == PU_DELAY - 1) begin m_st = 2; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (forcing) m_st = 0;
      end
      m_s2 = m_s1;
      m_s1 = int'(vdd_low);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e_rst, e_re;
    e_rst = (m_st != 2) ? 1 : 0;
    e_re  = ((bo_en != 0) && (bo_lvl == 0) && (m_s2 == 1)) ? 1 : 0;
    chk(int'(sys_rst) == e_rst, cur_req, int'(sys_rst), e_rst);
    chk(int'(bo_flag) == m_flag, "R9 flag", int'(bo_flag), m_flag);
    chk(int'(por_rearm) == e_re, "R8 rearm", int'(por_rearm), e_re);
    chk(lvl_sel == bo_lvl, "R10 level", int'(lvl_sel), int'(bo_lvl));
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    tick(2);
    chk(sys_rst == 1'b1, "R1 por holds", int'(sys_rst), 1);
    chk(bo_flag == 1'b0, "R1 flag clear", int'(bo_flag), 0);
    por = 1'b0;
    cur_req = "R5";
    tick(60);
    chk(sys_rst == 1'b1, "R5 inside delay", int'(sys_rst), 1);
    tick(10);
    chk(sys_rst == 1'b0, "R5 delay over", int'(sys_rst), 0);

    cur_req = "R3";
    vdd_low = 1'b1;
    tick(2);
    chk(sys_rst == 1'b0, "R3 sync latency", int'(sys_rst), 0);
    tick(1);
    chk(sys_rst == 1'b1, "R3 reset", int'(sys_rst), 1);
    cur_req = "R4";
    tick(10);
    chk(sys_rst == 1'b1, "R4 held", int'(sys_rst), 1);
    chk(bo_flag == 1'b1, "R9 set", int'(bo_flag), 1);
    vdd_low = 1'b0;
    cur_req = "R5";
    tick(40);
    chk(sys_rst == 1'b1, "R5 stretched", int'(sys_rst), 1);
    tick(40);
    chk(sys_rst == 1'b0, "R5 released", int'(sys_rst), 0);

    cur_req = "R7";
    vdd_low = 1'b1; tick(5);
    vdd_low = 1'b0; tick(20);
    vdd_low = 1'b1; tick(3);
    vdd_low = 1'b0; tick(60);
    chk(sys_rst == 1'b1, "R7 delay restarted", int'(sys_rst), 1);
    tick(20);
    chk(sys_rst == 1'b0, "R7 released", int'(sys_rst), 0);

    cur_req = "R6";
    pu_en = 1'b0;
    vdd_low = 1'b1; tick(5);
    chk(sys_rst == 1'b1, "R6 reset", int'(sys_rst), 1);
    vdd_low = 1'b0; tick(2);
    chk(sys_rst == 1'b1, "R6 still synced low", int'(sys_rst), 1);
    tick(1);
    chk(sys_rst == 1'b0, "R6 no delay", int'(sys_rst), 0);

    cur_req = "R9";
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk(bo_flag == 1'b0, "R9 cleared", int'(bo_flag), 0);
    vdd_low = 1'b1; flag_clr = 1'b1; tick(4);
    chk(bo_flag == 1'b1, "R9 set wins", int'(bo_flag), 1);
    flag_clr = 1'b0; vdd_low = 1'b0; tick(5);

    cur_req = "R2";
    bo_en = 2'b00;
    vdd_low = 1'b1; tick(10);
    chk(sys_rst == 1'b0, "R2 no reset", int'(sys_rst), 0);
    chk(por_rearm == 1'b0, "R2 no rearm", int'(por_rearm), 0);
    vdd_low = 1'b0; tick(3);

    cur_req = "R8";
    bo_en = 2'b11; bo_lvl = 2'b00;
    vdd_low = 1'b1; tick(3);
    chk(por_rearm == 1'b1, "R8 rearm", int'(por_rearm), 1);
    chk(sys_rst == 1'b0, "R8 no reset", int'(sys_rst), 0);
    vdd_low = 1'b0; tick(3);
    chk(por_rearm == 1'b0, "R8 rearm drops", int'(por_rearm), 0);

    for (int l = 0; l < 4; l++) begin
      bo_lvl = 2'(l); #1;
      chk(lvl_sel == 2'(l), "R10 passthrough", int'(lvl_sel), l);
    end

    cur_req = "R3";
    bo_en = 2'b10; bo_lvl = 2'b01;
    tick(1);
    vdd_low = 1'b1; tick(1); vdd_low = 1'b0;
    tick(2);
    chk(sys_rst == 1'b1, "R3 one-cycle pulse", int'(sys_rst), 1);
    tick(1);
    chk(sys_rst == 1'b0, "R6 pulse recovery", int'(sys_rst), 0);

    cur_req = "R1";
    por = 1'b1; tick(1);
    chk(bo_flag == 1'b0, "R1 por clears flag", int'(bo_flag), 0);
    chk(sys_rst == 1'b1, "R1 por reset", int'(sys_rst), 1);
    por = 1'b0; tick(5);
    chk(sys_rst == 1'b0, "R1 restart", int'(sys_rst), 0);

    report();
    $finish;
  end
endmodule